// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Access Port

This block lets a host on a 16-bit register bus reach two 16-bit memories that it cannot map directly: a shared communication RAM bank and the local RAM of a communication processor. The host sees four word registers: a control word, a byte pointer, a data window and a status word. Every read or write of the data window reaches the memory chosen by the control word. It uses the word at the pointer, and the pointer then moves on by one word (two bytes). This lets the host stream a buffer in or out with one register index.

One control bit picks the target memory. Another control bit drives the processor reset line. The memories sit outside the block and share one address bus and one write-data bus. Each memory has its own write enable and its own read-data input. A read is accepted on the clock edge where the read strobe is high. The read data is registered and holds steady from that edge until the next accepted read.

Top module: `iap_port`

## Requirements
- R1: After reset the control word reads 0xC000, the pointer reads 0, the status word reads 0 and `cpuResetN` is low.
- R2: Writes to index 0 (control) and index 1 (pointer) store the value. Reading either index returns the stored value, with the pointer zero-extended. These accesses never move the pointer.
- R3: Control bit 0 picks the window target. When it is 1, the local RAM is written (`localWrEn`) and read (`localRdData`). When it is 0, the communication RAM is used instead (`commWrEn`, `commRdData`). The write enable of the memory that is not selected stays low.
- R4: A window access (index 2) presents pointer bits [OFFSET_W-1:1] on `memAddr`, so an odd pointer reaches the same word as the even byte below it.
- R5: Each window write adds 2 to the pointer.
- R6: Each window read adds 2 to the pointer and returns the word at the pointer value from before the increment on `hostRdData` after that edge. Reads on consecutive cycles return consecutive words.
- R7: The pointer is OFFSET_W bits wide (16 by default) and wraps modulo 2^OFFSET_W when it is incremented.
- R8: `cpuResetN` equals control bit 5 from the edge that writes the control word. A 1 releases the processor and a 0 holds it in reset.
- R9: A write to index 3 loads the status word. Reading index 3 returns it, and neither access moves the pointer.
- R10: If the read and write strobes are high in the same cycle, only the write takes effect. `hostRdData` keeps its previous value and the pointer moves once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 2 | Register index: 0 control, 1 pointer, 2 window, 3 status |
| hostWrEn | input | 1 | Write strobe, one access per cycle |
| hostRdEn | input | 1 | Read strobe, one access per cycle |
| hostWrData | input | 16 | Write data |
| hostRdData | output | 16 | Registered read data |
| cpuResetN | output | 1 | Processor reset, low holds it in reset |
| memAddr | output | OFFSET_W-1 | Word address shared by both memories |
| memWrData | output | 16 | Write data shared by both memories |
| commWrEn | output | 1 | Communication RAM write enable |
| localWrEn | output | 1 | Local RAM write enable |
| commRdData | input | 16 | Communication RAM read data (combinational) |
| localRdData | input | 16 | Local RAM read data (combinational) |

## Verification
A pointer that is off by one word, or that misses an increment, moves every later window access. The symptom appears on the first mismatching word of a streamed buffer and in the pointer readback right after it. A wrong target select shows up as data in the wrong memory, or as a read that returns the other memory's contents, on that same access. A wrong reset-control bit shows up on `cpuResetN` one edge after the control write.

// File: rtl/iap_pkg.sv
package iap_pkg;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] CTRL_RESET = 16'hC000;
  localparam int SEL_BIT = 0;
  localparam int RUN_BIT = 5;

  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_OFFSET = 2'd1;
  localparam logic [1:0] IDX_WINDOW = 2'd2;
  localparam logic [1:0] IDX_STATUS = 2'd3;

  typedef struct packed {
    logic       ctrlWr;
    logic       offsetWr;
    logic       statusWr;
    logic       winWr;
    logic       winRd;
    logic       regRd;
    logic [1:0] rdIdx;
  } iapStrobe_t;
endpackage

// File: rtl/iap_ctrl.sv
module iap_ctrl
  import iap_pkg::*;
(
  input  logic [1:0] hostAddr,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  output iapStrobe_t stb
);
  logic rdAccepted;

  // A write in the same cycle suppresses the read.
  assign rdAccepted = hostRdEn && !hostWrEn;

  always_comb begin
    stb          = '0;
    stb.ctrlWr   = hostWrEn && (hostAddr == IDX_CTRL);
    stb.offsetWr = hostWrEn && (hostAddr == IDX_OFFSET);
    stb.winWr    = hostWrEn && (hostAddr == IDX_WINDOW);
    stb.statusWr = hostWrEn && (hostAddr == IDX_STATUS);
    stb.regRd    = rdAccepted;
    stb.winRd    = rdAccepted && (hostAddr == IDX_WINDOW);
    stb.rdIdx    = hostAddr;
  end
endmodule

// File: rtl/iap_datapath.sv
module iap_datapath
  import iap_pkg::*;
#(
  parameter int OFFSET_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  iapStrobe_t          stb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                cpuResetN,
  output logic [OFFSET_W-2:0] memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic                commWrEn,
  output logic                localWrEn,
  input  logic [DATA_W-1:0]   commRdData,
  input  logic [DATA_W-1:0]   localRdData
);
  localparam logic [OFFSET_W-1:0] STEP = OFFSET_W'(2);

  logic [DATA_W-1:0]   ctrlReg;
  logic [DATA_W-1:0]   statusReg;
  logic [DATA_W-1:0]   rdDataReg;
  logic [OFFSET_W-1:0] offsetReg;
  logic [DATA_W-1:0]   winData;
  logic [DATA_W-1:0]   rdMux;
  logic                useLocal;

  assign useLocal  = ctrlReg[SEL_BIT];
  assign winData   = useLocal ? localRdData : commRdData;
  assign memAddr   = offsetReg[OFFSET_W-1:1];
  assign memWrData = wrData;
  assign commWrEn  = stb.winWr && !useLocal;
  assign localWrEn = stb.winWr && useLocal;
  assign cpuResetN = ctrlReg[RUN_BIT];
  assign rdData    = rdDataReg;

  always_comb begin
    unique case (stb.rdIdx)
      IDX_CTRL:   rdMux = ctrlReg;
      IDX_OFFSET: rdMux = DATA_W'(offsetReg);
      IDX_WINDOW: rdMux = winData;
      default:    rdMux = statusReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= CTRL_RESET;
      statusReg <= '0;
      offsetReg <= '0;
      rdDataReg <= '0;
    end else begin
      if (stb.ctrlWr)   ctrlReg   <= wrData;
      if (stb.statusWr) statusReg <= wrData;
      if (stb.offsetWr)
        offsetReg <= wrData[OFFSET_W-1:0];
      else if (stb.winWr || stb.winRd)
        offsetReg <= offsetReg + STEP;
      if (stb.regRd)    rdDataReg <= rdMux;
    end
  end
endmodule

// File: rtl/iap_port.sv
module iap_port
  import iap_pkg::*;
#(
  parameter int OFFSET_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostAddr,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [15:0]         hostWrData,
  output logic [15:0]         hostRdData,
  output logic                cpuResetN,
  output logic [OFFSET_W-2:0] memAddr,
  output logic [15:0]         memWrData,
  output logic                commWrEn,
  output logic                localWrEn,
  input  logic [15:0]         commRdData,
  input  logic [15:0]         localRdData
);
  iapStrobe_t stb;

  iap_ctrl u_ctrl (
    .hostAddr (hostAddr),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .stb      (stb)
  );

  iap_datapath #(.OFFSET_W(OFFSET_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (hostWrData),
    .rdData      (hostRdData),
    .cpuResetN   (cpuResetN),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .commWrEn    (commWrEn),
    .localWrEn   (localWrEn),
    .commRdData  (commRdData),
    .localRdData (localRdData)
  );
endmodule

// File: rtl/iap_port_chk.sv
module iap_port_chk #(
  parameter int OFFSET_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          hostAddr,
  input logic                hostWrEn,
  input logic                hostRdEn,
  input logic                wrBitSel,
  input logic                wrBitRun,
  input logic                cpuResetN,
  input logic [OFFSET_W-2:0] memAddr,
  input logic                commWrEn,
  input logic                localWrEn
);
  localparam int MEM_AW = OFFSET_W - 1;

  // Target select as the host last wrote it (reset value has bit 0 clear).
  logic shadowSel;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowSel <= 1'b0;
    else if (hostWrEn && hostAddr == 2'd0) shadowSel <= wrBitSel;
  end

  assert_comm_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    commWrEn |-> !shadowSel);

  assert_local_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    localWrEn |-> shadowSel);

  assert_write_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd2) |=> (memAddr == MEM_AW'($past(memAddr) + 1'b1)));

  assert_read_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && hostAddr == 2'd2) |=> (memAddr == MEM_AW'($past(memAddr) + 1'b1)));

  assert_pointer_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWrEn || hostRdEn) && (hostAddr == 2'd0 || hostAddr == 2'd3)) |=> $stable(memAddr));

  assert_reset_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0) |=> (cpuResetN == $past(wrBitRun)));
endmodule

bind iap_port iap_port_chk #(.OFFSET_W(OFFSET_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostAddr  (hostAddr),
  .hostWrEn  (hostWrEn),
  .hostRdEn  (hostRdEn),
  .wrBitSel  (hostWrData[0]),
  .wrBitRun  (hostWrData[5]),
  .cpuResetN (cpuResetN),
  .memAddr   (memAddr),
  .commWrEn  (commWrEn),
  .localWrEn (localWrEn)
);

// File: tb/iap_port_tb.sv
module iap_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFFSET_W   = 9;
  localparam int WORDS      = 1 << (OFFSET_W - 1);
  localparam int PTR_MOD    = 1 << OFFSET_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        cpuResetN;
  logic [OFFSET_W-2:0] memAddr;
  logic [15:0] memWrData;
  logic        commWrEn, localWrEn;
  logic [15:0] commRdData, localRdData;

  logic [15:0] commMem  [WORDS];
  logic [15:0] localMem [WORDS];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign commRdData  = commMem[memAddr];
  assign localRdData = localMem[memAddr];

  always @(posedge clk) begin
    if (commWrEn)  commMem[memAddr]  <= memWrData;
    if (localWrEn) localMem[memAddr] <= memWrData;
  end

  iap_port #(.OFFSET_W(OFFSET_W)) u_dut (
    .clk, .rstN, .hostAddr, .hostWrEn, .hostRdEn, .hostWrData, .hostRdData,
    .cpuResetN, .memAddr, .memWrData, .commWrEn, .localWrEn,
    .commRdData, .localRdData
  );

  function automatic logic [15:0] patComm(int i);
    return 16'((i * 16'h0101) ^ 16'h5A3C);
  endfunction
  function automatic logic [15:0] patLocal(int i);
    return 16'((i << 7) ^ 16'hC3A5);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic hostWrite(logic [1:0] idx, logic [15:0] d);
    hostAddr = idx; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [1:0] idx, output logic [15:0] d);
    hostAddr = idx; hostRdEn = 1'b1;
    @(negedge clk);
    d = hostRdData;
    hostRdEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    int bad;
    for (int i = 0; i < WORDS; i++) begin commMem[i] = '0; localMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset nreset", {15'd0, cpuResetN}, 16'd0);
    hostRead(2'd0, v); check("R1 ctrl", v, 16'hC000);
    hostRead(2'd1, v); check("R1 ptr", v, 16'd0);
    hostRead(2'd3, v); check("R1 status", v, 16'd0);

    // R8 reset control
    hostWrite(2'd0, 16'h0020);
    check("R8 release", {15'd0, cpuResetN}, 16'd1);
    hostWrite(2'd0, 16'h0000);
    check("R8 hold", {15'd0, cpuResetN}, 16'd0);

    // R2 register storage, no pointer motion
    hostWrite(2'd0, 16'h1234);
    hostRead(2'd0, v); check("R2 ctrl", v, 16'h1234);
    check("R8 bit5 of 1234", {15'd0, cpuResetN}, 16'd1);
    hostWrite(2'd1, 16'h01AB);
    hostRead(2'd1, v); hostRead(2'd1, v); check("R2 ptr stable", v, 16'h01AB);

    // R9 status
    hostWrite(2'd3, 16'hBEEF);
    hostRead(2'd3, v); check("R9 status", v, 16'hBEEF);
    hostRead(2'd1, v); check("R9 ptr untouched", v, 16'h01AB);

    // R3 R4 R5 R7 full sweep of communication RAM
    hostWrite(2'd0, 16'h0000);
    hostWrite(2'd1, 16'h0000);
    for (int i = 0; i < WORDS; i++) hostWrite(2'd2, patComm(i));
    hostRead(2'd1, v); check("R7 wrap after write sweep", v, 16'((2*WORDS) % PTR_MOD));
    // Local RAM sweep must leave communication RAM untouched
    hostWrite(2'd0, 16'h0001);
    for (int i = 0; i < WORDS; i++) hostWrite(2'd2, patLocal(i));
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      if (commMem[i] !== patComm(i) || localMem[i] !== patLocal(i)) begin
        bad++;
        if (bad == 1) check("R3 R5 memory contents", commMem[i], patComm(i));
      end
    end
    check("R3 R4 R5 mismatch count", 16'(bad), 16'd0);

    // R6 streamed reads, both targets
    hostWrite(2'd0, 16'h0000);
    hostWrite(2'd1, 16'h0000);
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      hostRead(2'd2, v);
      if (v !== patComm(i)) begin bad++; if (bad == 1) check("R6 comm stream", v, patComm(i)); end
    end
    check("R6 comm stream errors", 16'(bad), 16'd0);
    hostRead(2'd1, v); check("R7 wrap after read sweep", v, 16'd0);
    hostWrite(2'd0, 16'h0001);
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      hostRead(2'd2, v);
      if (v !== patLocal(i)) begin bad++; if (bad == 1) check("R3 R6 local stream", v, patLocal(i)); end
    end
    check("R3 R6 local stream errors", 16'(bad), 16'd0);

    // R4 odd pointer
    hostWrite(2'd0, 16'h0000);
    hostWrite(2'd1, 16'h00F5);
    hostRead(2'd2, v); check("R4 odd pointer data", v, patComm(8'h7A));
    hostRead(2'd1, v); check("R4 odd pointer advance", v, 16'h00F7);

    // R7 last word then wrap
    hostWrite(2'd1, 16'h01FE);
    hostWrite(2'd2, 16'hA55A);
    check("R7 last word", commMem[WORDS-1], 16'hA55A);
    hostRead(2'd1, v); check("R7 wrap to zero", v, 16'd0);

    // R10 read and write together
    hostWrite(2'd1, 16'h0010);
    hostRead(2'd3, held);
    hostAddr = 2'd2; hostWrData = 16'h7E7E; hostWrEn = 1'b1; hostRdEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0;
    check("R10 read data held", hostRdData, held);
    check("R10 write done", commMem[8], 16'h7E7E);
    hostRead(2'd1, v); check("R10 single advance", v, 16'h0012);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule